// File: doc/BRIEF.md
# Paired-Byte Auto-Increment Program Sequencer

This block runs the sequential "word program" mode of a serial NOR flash model. An SPI front end shifts the serial input into whole bytes and hands each byte over with a one-cycle strobe. It also passes the chip-select level. The block counts the bytes of each chip-select frame on its own. It detects the chip-select rising edge, and when a complete and permitted program frame ends, it writes two bytes, one after the other, to the memory-array write port. It then holds a busy flag for a self-timed program period whose length is a parameter.

The block keeps the mode flag and the pointer to the next two-byte pair between frames. The first frame of a run carries an address. Each later frame carries only the two data bytes. There is no wrap-around: once the pair that ends on the highest writable address has been programmed, the mode closes by itself. The protection decode outside the block supplies that highest writable address. The write-enable latch also lives outside the block: it arrives as an input, and the block requests that it be cleared through a one-cycle pulse. An optional setting makes the serial output carry a ready/busy level while chip select is low during the mode.

Top module: `aai_word_seq`

## Requirements
- R1: A run begins with a frame of exactly six bytes: opcode ADh, then three address bytes (bits 23:16 first, then 15:8, then 7:0), then two data bytes. A frame of any other length starts nothing.
- R2: The first data byte is written to the address with bit 0 forced to 0, and the second byte to the same address with bit 0 forced to 1. The two writes happen in two consecutive cycles, with the even address first.
- R3: While the mode is active, an ADh frame of exactly three bytes (opcode plus two data bytes) programs the pair that follows the previous one: the pointer advances by 2.
- R4: Programming starts only in the cycle after the clock edge that first sees chip select high, and only if `wel` is 1 and the odd address of the target pair is not above `lim_addr`. Otherwise nothing is written and the mode flag is unchanged.
- R5: While the mode is active, opcodes 70h and 80h have no effect. Opcode 04h (a one-byte frame) ends the mode and pulses `wel_clr` for one cycle.
- R6: When the pair whose odd address equals `lim_addr` completes, the mode flag drops and `wel_clr` pulses for one cycle. The address never wraps.
- R7: `aai_flag` (status bit 6 for the status reader) is 1 from the cycle the first pair starts until the mode ends, and 0 otherwise.
- R8: `busy` is high for exactly PROG_CYC+2 cycles from the cycle after an accepted frame's chip-select rising edge. An ADh frame that ends while `busy` is high is dropped and does not move the pointer.
- R9: After a one-byte frame 70h, sent outside the mode, `so_oe` is 1 whenever chip select is low while the mode is active, and `so_lvl` is 0 while busy and 1 while ready. Chip select high makes `so_oe` 0. A one-byte frame 80h, sent outside the mode, turns this off.
- R10: After reset, `busy`, `aai_flag`, `wr_en`, `wel_clr` and `so_oe` are 0, and serial-output busy signalling is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| byte_valid | input | 1 | One-cycle strobe: a whole byte has been shifted in |
| byte_in | input | 8 | Byte received from the serial input |
| wel | input | 1 | Write-enable latch state |
| lim_addr | input | 24 | Highest writable address from protection decode |
| wr_en | output | 1 | Array write strobe |
| wr_addr | output | 24 | Array write address |
| wr_data | output | 8 | Array write data |
| busy | output | 1 | Self-timed program in progress |
| aai_flag | output | 1 | Mode active (status bit 6) |
| wel_clr | output | 1 | One-cycle request to clear the write-enable latch |
| so_oe | output | 1 | Drive serial output with the ready/busy level |
| so_lvl | output | 1 | Ready/busy level: 1 ready, 0 busy |

## Verification
The main function is exercised with several frame patterns. An odd start address shows that bit 0 is forced. Continuation frames show the pointer advancing by two. A frame sent during busy must be dropped without moving the pointer. A run stopped by the write limit is told apart from one stopped by opcode 04h. Rejected frames cover a wrong byte count, `wel` low, a target above the limit, and a short frame sent outside the mode; each must leave both the writes and the flag untouched. The serial-output level is compared while chip select is low, both during busy and after it, with the setting on and after it has been turned off. Opcode 80h sent inside the mode must not change the setting.

// File: rtl/aai_pkg.sv
package aai_pkg;

    localparam int ADDR_W = 24;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 3;

    localparam logic [BYTE_W-1:0] OP_PAIR_PROG  = 8'hAD;
    localparam logic [BYTE_W-1:0] OP_WREN_OFF   = 8'h04;
    localparam logic [BYTE_W-1:0] OP_SOBSY_ON   = 8'h70;
    localparam logic [BYTE_W-1:0] OP_SOBSY_OFF  = 8'h80;

    localparam logic [CNT_W-1:0] LEN_OPEN  = 3'd6;
    localparam logic [CNT_W-1:0] LEN_CONT  = 3'd3;
    localparam logic [CNT_W-1:0] LEN_SHORT = 3'd1;
    localparam logic [CNT_W-1:0] LEN_SAT   = 3'd7;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_LO,
        PS_HI,
        PS_WAIT
    } pstate_t;

    typedef struct packed {
        logic [BYTE_W-1:0] op;
        logic [CNT_W-1:0]  nbytes;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] d0;
        logic [BYTE_W-1:0] d1;
    } frame_t;

    function automatic logic [ADDR_W-1:0] pair_odd(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:1], 1'b1};
    endfunction

    function automatic logic [ADDR_W-1:0] pair_even(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:1], 1'b0};
    endfunction

endpackage

// File: rtl/aai_frame_rx.sv
module aai_frame_rx
    import aai_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              aai,
    output logic              cs_rise,
    output frame_t            fr
);

    logic cs_q;

    assign cs_rise = cs_n && !cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q <= 1'b1;
            fr   <= '0;
        end else begin
            cs_q <= cs_n;
            if (cs_n) begin
                fr.nbytes <= '0;
            end else if (byte_valid) begin
                case (fr.nbytes)
                    3'd0: fr.op <= byte_in;
                    3'd1: if (aai) fr.d0 <= byte_in; else fr.addr[23:16] <= byte_in;
                    3'd2: if (aai) fr.d1 <= byte_in; else fr.addr[15:8]  <= byte_in;
                    3'd3: if (!aai) fr.addr[7:0] <= byte_in;
                    3'd4: if (!aai) fr.d0 <= byte_in;
                    3'd5: if (!aai) fr.d1 <= byte_in;
                    default: ;
                endcase
                if (fr.nbytes != LEN_SAT)
                    fr.nbytes <= fr.nbytes + 1'b1;
            end
        end
    end

endmodule

// File: rtl/aai_prog_ctl.sv
module aai_prog_ctl
    import aai_pkg::*;
#(
    parameter int PROG_CYC = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_rise,
    input  frame_t            fr,
    input  logic              wel,
    input  logic [ADDR_W-1:0] lim,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              busy,
    output logic              aai,
    output logic              hwb_en,
    output logic              wel_clr
);

    localparam int TW = $clog2(PROG_CYC + 1);
    localparam logic [TW-1:0] T_LOAD = TW'(PROG_CYC - 1);

    pstate_t           st;
    logic [TW-1:0]     tmr;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] cur;
    logic [BYTE_W-1:0] dat0, dat1;

    logic is_pair, is_short, go_open, go_cont, hit_off, hit_on, hit_quiet;

    always_comb begin
        is_pair   = cs_rise && (fr.op == OP_PAIR_PROG) && (st == PS_IDLE) && wel;
        is_short  = cs_rise && (fr.nbytes == LEN_SHORT);
        go_open   = is_pair && !aai && (fr.nbytes == LEN_OPEN) && (pair_odd(fr.addr) <= lim);
        go_cont   = is_pair && aai && (fr.nbytes == LEN_CONT) && (pair_odd(ptr) <= lim);
        hit_off   = is_short && (fr.op == OP_WREN_OFF);
        hit_on    = is_short && !aai && (fr.op == OP_SOBSY_ON);
        hit_quiet = is_short && !aai && (fr.op == OP_SOBSY_OFF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= PS_IDLE;
            tmr     <= '0;
            ptr     <= '0;
            cur     <= '0;
            dat0    <= '0;
            dat1    <= '0;
            aai     <= 1'b0;
            hwb_en  <= 1'b0;
            wel_clr <= 1'b0;
        end else begin
            wel_clr <= 1'b0;
            case (st)
                PS_IDLE: begin
                    if (go_open) begin
                        cur  <= pair_even(fr.addr);
                        dat0 <= fr.d0;
                        dat1 <= fr.d1;
                        aai  <= 1'b1;
                        st   <= PS_LO;
                    end else if (go_cont) begin
                        cur  <= ptr;
                        dat0 <= fr.d0;
                        dat1 <= fr.d1;
                        st   <= PS_LO;
                    end
                end
                PS_LO: st <= PS_HI;
                PS_HI: begin
                    st  <= PS_WAIT;
                    tmr <= T_LOAD;
                end
                PS_WAIT: begin
                    if (tmr == '0) begin
                        st <= PS_IDLE;
                        if (aai) begin
                            if (pair_odd(cur) == lim) begin
                                aai     <= 1'b0;
                                wel_clr <= 1'b1;
                            end else begin
                                ptr <= cur + ADDR_W'(2);
                            end
                        end
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                default: st <= PS_IDLE;
            endcase
            if (hit_off) begin
                aai     <= 1'b0;
                wel_clr <= 1'b1;
            end
            if (hit_on)
                hwb_en <= 1'b1;
            else if (hit_quiet)
                hwb_en <= 1'b0;
        end
    end

    assign busy    = (st != PS_IDLE);
    assign wr_en   = (st == PS_LO) || (st == PS_HI);
    assign wr_addr = {cur[ADDR_W-1:1], (st == PS_HI)};
    assign wr_data = (st == PS_HI) ? dat1 : dat0;

endmodule

// File: rtl/aai_so_drv.sv
module aai_so_drv (
    input  logic cs_n,
    input  logic aai,
    input  logic hwb_en,
    input  logic busy,
    output logic so_oe,
    output logic so_lvl
);

    assign so_oe  = hwb_en && aai && !cs_n;
    assign so_lvl = !busy;

endmodule

// File: rtl/aai_word_seq.sv
module aai_word_seq
    import aai_pkg::*;
#(
    parameter int PROG_CYC = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        byte_valid,
    input  logic [7:0]  byte_in,
    input  logic        wel,
    input  logic [23:0] lim_addr,
    output logic        wr_en,
    output logic [23:0] wr_addr,
    output logic [7:0]  wr_data,
    output logic        busy,
    output logic        aai_flag,
    output logic        wel_clr,
    output logic        so_oe,
    output logic        so_lvl
);

    logic   cs_rise;
    logic   hwb_en;
    frame_t fr;

    aai_frame_rx u_rx (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .aai        (aai_flag),
        .cs_rise    (cs_rise),
        .fr         (fr)
    );

    aai_prog_ctl #(.PROG_CYC(PROG_CYC)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .cs_rise (cs_rise),
        .fr      (fr),
        .wel     (wel),
        .lim     (lim_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .busy    (busy),
        .aai     (aai_flag),
        .hwb_en  (hwb_en),
        .wel_clr (wel_clr)
    );

    aai_so_drv u_so (
        .cs_n   (cs_n),
        .aai    (aai_flag),
        .hwb_en (hwb_en),
        .busy   (busy),
        .so_oe  (so_oe),
        .so_lvl (so_lvl)
    );

endmodule

// File: rtl/aai_word_seq_chk.sv
module aai_word_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        cs_n,
    input logic        wr_en,
    input logic [23:0] wr_addr,
    input logic        busy,
    input logic        aai_flag,
    input logic        wel_clr,
    input logic        so_oe
);

    AST_PAIR_ORDER: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_addr[0]) |=> (wr_en && wr_addr[0])); // R2

    AST_PAIR_SAME_WORD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_addr[0]) |=> (wr_addr[23:1] == $past(wr_addr[23:1]))); // R2

    AST_WRITE_UNDER_BUSY: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy); // R8

    AST_SO_QUIET_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !so_oe); // R9

    AST_SO_ONLY_IN_MODE: assert property (@(posedge clk) disable iff (rst)
        so_oe |-> aai_flag); // R9

    AST_CLEAR_LEAVES_MODE: assert property (@(posedge clk) disable iff (rst)
        wel_clr |-> !aai_flag); // R5

    AST_ENTER_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(aai_flag) |-> ($past(cs_n) && busy)); // R4

endmodule

bind aai_word_seq aai_word_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .busy     (busy),
    .aai_flag (aai_flag),
    .wel_clr  (wel_clr),
    .so_oe    (so_oe)
);

// File: tb/sim_aai_word_seq.sv
module sim_aai_word_seq;

    localparam int P = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic        wel = 1'b0;
    logic [23:0] lim_addr = 24'h1FFFFF;
    logic        wr_en, busy, aai_flag, wel_clr, so_oe, so_lvl;
    logic [23:0] wr_addr;
    logic [7:0]  wr_data;

    aai_word_seq #(.PROG_CYC(P)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .byte_valid(byte_valid), .byte_in(byte_in),
        .wel(wel), .lim_addr(lim_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .aai_flag(aai_flag), .wel_clr(wel_clr), .so_oe(so_oe), .so_lvl(so_lvl)
    );

    always #5 clk = ~clk;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // behavioural reference state
    int m_cnt, m_tmr;
    bit m_csq, m_aai, m_hwb, m_clr;
    logic [7:0]  m_op, m_d0, m_d1, m_w0, m_w1;
    logic [23:0] m_addr, m_ptr, m_cur;

    logic [23:0] log_a[$];
    logic [7:0]  log_d[$];

    task automatic chk(input string rq, input string nm, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s got %0h exp %0h", rq, nm, got, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_tmr = 0; m_csq = 1; m_aai = 0; m_hwb = 0; m_clr = 0;
            m_op = 0; m_d0 = 0; m_d1 = 0; m_w0 = 0; m_w1 = 0;
            m_addr = 0; m_ptr = 0; m_cur = 0;
        end else begin
            bit rise, a_old;
            int t_old;
            rise  = cs_n && !m_csq;
            a_old = m_aai;
            t_old = m_tmr;
            m_clr = 0;
            if (t_old > 0) m_tmr = t_old - 1;
            if (t_old == 1 && m_aai) begin
                if ((m_cur | 24'h1) == lim_addr) begin m_aai = 0; m_clr = 1; end
                else m_ptr = m_cur + 2;
            end
            if (rise) begin
                if (m_op == 8'h04 && m_cnt == 1) begin m_aai = 0; m_clr = 1; end
                if (m_op == 8'h70 && m_cnt == 1 && !a_old) m_hwb = 1;
                if (m_op == 8'h80 && m_cnt == 1 && !a_old) m_hwb = 0;
                if (m_op == 8'hAD && t_old == 0 && wel) begin
                    if (!a_old && m_cnt == 6 && ((m_addr | 24'h1) <= lim_addr)) begin
                        m_cur = m_addr & 24'hFFFFFE; m_aai = 1; m_tmr = P + 2;
                        m_w0 = m_d0; m_w1 = m_d1;
                    end else if (a_old && m_cnt == 3 && ((m_ptr | 24'h1) <= lim_addr)) begin
                        m_cur = m_ptr; m_tmr = P + 2; m_w0 = m_d0; m_w1 = m_d1;
                    end
                end
            end
            if (cs_n) m_cnt = 0;
            else if (byte_valid) begin
                case (m_cnt)
                    0: m_op = byte_in;
                    1: if (a_old) m_d0 = byte_in; else m_addr[23:16] = byte_in;
                    2: if (a_old) m_d1 = byte_in; else m_addr[15:8] = byte_in;
                    3: if (!a_old) m_addr[7:0] = byte_in;
                    4: if (!a_old) m_d0 = byte_in;
                    5: if (!a_old) m_d1 = byte_in;
                    default: ;
                endcase
                if (m_cnt < 7) m_cnt++;
            end
            m_csq = cs_n;
        end
        #1;
        begin
            bit e_wr, e_oe;
            e_wr = (m_tmr == P + 2) || (m_tmr == P + 1);
            e_oe = m_hwb && m_aai && !cs_n;
            chk("R4", "wr_en", wr_en, e_wr);
            if (e_wr) begin
                chk("R2", "wr_addr", wr_addr, (m_tmr == P + 1) ? (m_cur | 24'h1) : m_cur);
                chk("R2", "wr_data", wr_data, (m_tmr == P + 1) ? m_w1 : m_w0);
            end
            chk("R8", "busy", busy, m_tmr > 0);
            chk("R7", "aai_flag", aai_flag, m_aai);
            chk("R6", "wel_clr", wel_clr, m_clr);
            chk("R9", "so_oe", so_oe, e_oe);
            if (e_oe) chk("R9", "so_lvl", so_lvl, m_tmr == 0);
            if (!rst && wr_en) begin log_a.push_back(wr_addr); log_d.push_back(wr_data); end
        end
    end

    task automatic frame(input int n, input logic [7:0] b0, b1, b2, b3, b4, b5);
        logic [7:0] bs [6];
        bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3; bs[4] = b4; bs[5] = b5;
        @(negedge clk) cs_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); byte_valid = 1'b1; byte_in = bs[i];
            @(negedge clk); byte_valid = 1'b0;
        end
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [23:0] ea [14];
        logic [7:0]  ed [14];
        idle(3);
        rst = 1'b0;
        idle(1);
        // R10 reset state
        chk("R10", "busy", busy, 0);
        chk("R10", "aai_flag", aai_flag, 0);
        chk("R10", "so_oe", so_oe, 0);
        chk("R10", "wr_en", wr_en, 0);

        frame(1, 8'h70, 0, 0, 0, 0, 0);
        wel = 1'b1;
        // R1: odd start address, bit 0 forced
        frame(6, 8'hAD, 8'h00, 8'h01, 8'h03, 8'hA1, 8'hB2);
        chk("R7", "aai after open", aai_flag, 1);
        chk("R8", "busy after open", busy, 1);
        // R8: frame during busy dropped
        frame(3, 8'hAD, 8'hEE, 8'hFF, 0, 0, 0);
        idle(P + 4);
        // R3 continuation
        frame(3, 8'hAD, 8'hC3, 8'hD4, 0, 0, 0);
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk);
        chk("R9", "so_oe busy", so_oe, 1);
        chk("R9", "so_lvl busy", so_lvl, 0);
        cs_n = 1'b1;
        idle(P + 4);
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk);
        chk("R9", "so_lvl ready", so_lvl, 1);
        cs_n = 1'b1;
        idle(2);
        // R5: 80h ignored inside mode
        frame(1, 8'h80, 0, 0, 0, 0, 0);
        frame(3, 8'hAD, 8'hE5, 8'hF6, 0, 0, 0);
        idle(P + 4);
        // R5: 04h ends mode
        frame(1, 8'h04, 0, 0, 0, 0, 0);
        chk("R5", "aai after 04", aai_flag, 0);
        wel = 1'b0;
        // R4: wel low
        frame(6, 8'hAD, 8'h00, 8'h02, 8'h00, 8'h11, 8'h22);
        idle(4);
        chk("R4", "aai wel low", aai_flag, 0);
        // R6: limit exit
        wel = 1'b1;
        lim_addr = 24'h00010F;
        frame(6, 8'hAD, 8'h00, 8'h01, 8'h0C, 8'h31, 8'h32);
        idle(P + 4);
        frame(3, 8'hAD, 8'h41, 8'h42, 0, 0, 0);
        idle(P + 4);
        chk("R6", "aai after limit", aai_flag, 0);
        // R1: short frame outside mode
        frame(3, 8'hAD, 8'h51, 8'h52, 0, 0, 0);
        idle(4);
        chk("R1", "aai short frame", aai_flag, 0);
        // R4: target above limit
        frame(6, 8'hAD, 8'h00, 8'h02, 8'h00, 8'h61, 8'h62);
        idle(4);
        chk("R4", "aai protected", aai_flag, 0);
        lim_addr = 24'h1FFFFF;
        // R1: wrong length
        frame(5, 8'hAD, 8'h00, 8'h01, 8'h00, 8'h71, 0);
        idle(4);
        chk("R1", "aai five bytes", aai_flag, 0);
        // R9: 80h outside mode turns signalling off
        frame(1, 8'h80, 0, 0, 0, 0, 0);
        frame(6, 8'hAD, 8'h00, 8'h03, 8'h00, 8'h81, 8'h82);
        idle(P + 4);
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk);
        chk("R9", "so_oe off", so_oe, 0);
        cs_n = 1'b1;
        idle(2);
        frame(3, 8'hAD, 8'h91, 8'h92, 0, 0, 0);
        idle(P + 4);
        frame(1, 8'h04, 0, 0, 0, 0, 0);
        idle(2);

        ea = '{24'h102, 24'h103, 24'h104, 24'h105, 24'h106, 24'h107, 24'h10C,
               24'h10D, 24'h10E, 24'h10F, 24'h300, 24'h301, 24'h302, 24'h303};
        ed = '{8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5, 8'hF6, 8'h31,
               8'h32, 8'h41, 8'h42, 8'h81, 8'h82, 8'h91, 8'h92};
        chk("R3", "write count", log_a.size(), 14);
        for (int i = 0; i < 14; i++) begin
            if (i < log_a.size()) begin
                chk("R2", "logged addr", log_a[i], ea[i]);
                chk("R3", "logged data", log_d[i], ed[i]);
            end
        end
        done = 1;
        summary();
    end

endmodule